// File: doc/BRIEF.md
# Spike-Gated Synaptic Crossbar Array

This block produces the input currents for one square tile of a spiking neural network. Every clock cycle it can accept one tile pass. A pass is a vector of binary presynaptic spikes, a full matrix of signed 8-bit synaptic weights and a small tag. For each postsynaptic neuron (one column of the matrix) the block adds up the weights whose presynaptic spike is set. All column sums come out together, a fixed number of cycles later.

A spike is a single bit, so each weight is either passed on or replaced by zero. No multiplier is used. The gated weights are sign-extended and reduced by a binary adder tree that has one register stage per level. The tree is one pass wide, so it takes a new tile every cycle. The tag travels with the data, and downstream neuron logic uses it to tell which tile a set of sums belongs to. Weight storage, the tile sequencing and the neuron state updates are outside this block.

Top module: `xbar_spike_array`

## Requirements
- R1: Output column j equals the signed sum, over every presynaptic input i whose spike bit in_spikes[i] is 1, of weight w[j][i]. Inputs whose spike bit is 0 add nothing.
- R2: Weight w[j][i] is the two's-complement byte at in_weights[(j*N_PRE+i)*8 +: 8]. Column sum j is out_sums[j*SUM_W +: SUM_W]. With a single spike at input i, each column j returns w[j][i] sign-extended.
- R3: When no spike bit is set, every column sum is zero whatever the weights. When every spike bit is set, each column sum is the plain sum of that column's weights.
- R4: out_valid is high exactly LAT = log2(N_PRE) cycles (4 by default) after a cycle with in_valid high.
- R5: out_tag presented with a valid output equals the in_tag that entered with the same pass.
- R6: A cycle with in_valid low gives a cycle with out_valid low LAT cycles later. Back-to-back valid passes come out on consecutive cycles, so the block accepts one pass per cycle.
- R7: While reset is asserted, and for the first LAT cycles after it is released, out_valid is low.
- R8: Sums are SUM_W = 8 + log2(N_PRE) bits wide (12 by default) and cannot overflow. All weights at -128 with all spikes set gives -2048, and all weights at 127 gives 2032.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks a tile pass on the inputs this cycle |
| in_tag | input | TAG_W | Tile tag, carried with the pass |
| in_spikes | input | N_PRE | Binary presynaptic spikes, one bit per input |
| in_weights | input | N_POST*N_PRE*W_BITS | Signed weight matrix, entry w[j][i] at (j*N_PRE+i)*W_BITS |
| out_valid | output | 1 | Marks valid sums and tag |
| out_tag | output | TAG_W | Tag of the pass whose sums are shown |
| out_sums | output | N_POST*SUM_W | Signed column sums, column j at j*SUM_W |

## Verification
The bench drives zero-spike passes with random weights. A design that fails to gate the weights would show non-zero currents there. Extreme matrices of all -128 and all 127 with every spike set expose a tree that is too narrow or drops the sign extension, because it would wrap to a positive value or lose the top bit. Single-spike passes walk across the inputs, so a swapped row/column index or a misplaced byte lands on the wrong column. Passes with the valid bit low are mixed into long random back-to-back traffic with changing tags. An off-by-one latency, a stuck valid, or a tag that slips by one stage shows up as a valid flag or tag in the wrong cycle.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    // Width of a column sum that cannot overflow for npre inputs of wb bits.
    function automatic int sum_width(input int wb, input int npre);
        return wb + $clog2(npre);
    endfunction

    // Number of pairwise adder levels, one register each.
    function automatic int tree_levels(input int npre);
        return $clog2(npre);
    endfunction

endpackage

// File: rtl/xbar_gate.sv
module xbar_gate #(
    parameter int N_PRE  = 16,
    parameter int N_POST = 16,
    parameter int W_BITS = 8,
    parameter int SUM_W  = 12
) (
    input  logic [N_PRE-1:0]                        spikes,
    input  logic [N_POST*N_PRE*W_BITS-1:0]          weights,
    output logic [N_POST-1:0][N_PRE-1:0][SUM_W-1:0] gated
);

    localparam int EXT_W = SUM_W - W_BITS;

    // A spike selects the weight, sign-extended to the sum width; no spike gives zero.
    always_comb begin
        for (int j = 0; j < N_POST; j++) begin
            for (int i = 0; i < N_PRE; i++) begin
                logic [W_BITS-1:0] wt;
                wt = weights[(j*N_PRE+i)*W_BITS +: W_BITS];
                gated[j][i] = spikes[i] ? {{EXT_W{wt[W_BITS-1]}}, wt} : '0;
            end
        end
    end

endmodule

// File: rtl/xbar_add_level.sv
module xbar_add_level #(
    parameter int N_POST = 16,
    parameter int IN_N   = 16,
    parameter int SUM_W  = 12,
    parameter int TAG_W  = 4
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       in_vld,
    input  logic [TAG_W-1:0]                           in_tag,
    input  logic [N_POST-1:0][IN_N-1:0][SUM_W-1:0]     in_sums,
    output logic                                       out_vld,
    output logic [TAG_W-1:0]                           out_tag,
    output logic [N_POST-1:0][IN_N/2-1:0][SUM_W-1:0]   out_sums
);

    localparam int OUT_N = IN_N / 2;

    typedef struct packed {
        logic                                   vld;
        logic [TAG_W-1:0]                       tag;
        logic [N_POST-1:0][OUT_N-1:0][SUM_W-1:0] sums;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.tag = in_tag;
            for (int j = 0; j < N_POST; j++) begin
                for (int k = 0; k < OUT_N; k++) begin
                    st_d.sums[j][k] = SUM_W'($signed(in_sums[j][2*k]) +
                                             $signed(in_sums[j][2*k+1]));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld  = st_q.vld;
    assign out_tag  = st_q.tag;
    assign out_sums = st_q.sums;

endmodule

// File: rtl/xbar_spike_array.sv
module xbar_spike_array #(
    parameter int N_PRE  = 16,
    parameter int N_POST = 16,
    parameter int W_BITS = 8,
    parameter int TAG_W  = 4,
    parameter int SUM_W  = xbar_pkg::sum_width(W_BITS, N_PRE)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [TAG_W-1:0]               in_tag,
    input  logic [N_PRE-1:0]               in_spikes,
    input  logic [N_POST*N_PRE*W_BITS-1:0] in_weights,
    output logic                           out_valid,
    output logic [TAG_W-1:0]               out_tag,
    output logic [N_POST*SUM_W-1:0]        out_sums
);

    localparam int LEVELS = xbar_pkg::tree_levels(N_PRE);

    logic [N_POST-1:0][N_PRE-1:0][SUM_W-1:0] gated;

    xbar_gate #(
        .N_PRE (N_PRE),
        .N_POST(N_POST),
        .W_BITS(W_BITS),
        .SUM_W (SUM_W)
    ) u_gate (
        .spikes (in_spikes),
        .weights(in_weights),
        .gated  (gated)
    );

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int IN_N = N_PRE >> l;

        logic                                     lv_vld_in;
        logic [TAG_W-1:0]                         lv_tag_in;
        logic [N_POST-1:0][IN_N-1:0][SUM_W-1:0]   lv_sums_in;
        logic                                     lv_vld;
        logic [TAG_W-1:0]                         lv_tag;
        logic [N_POST-1:0][IN_N/2-1:0][SUM_W-1:0] lv_sums;

        if (l == 0) begin : g_head
            assign lv_vld_in  = in_valid;
            assign lv_tag_in  = in_tag;
            assign lv_sums_in = gated;
        end else begin : g_link
            assign lv_vld_in  = g_lvl[l-1].lv_vld;
            assign lv_tag_in  = g_lvl[l-1].lv_tag;
            assign lv_sums_in = g_lvl[l-1].lv_sums;
        end

        xbar_add_level #(
            .N_POST(N_POST),
            .IN_N  (IN_N),
            .SUM_W (SUM_W),
            .TAG_W (TAG_W)
        ) u_level (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_vld  (lv_vld_in),
            .in_tag  (lv_tag_in),
            .in_sums (lv_sums_in),
            .out_vld (lv_vld),
            .out_tag (lv_tag),
            .out_sums(lv_sums)
        );
    end

    assign out_valid = g_lvl[LEVELS-1].lv_vld;
    assign out_tag   = g_lvl[LEVELS-1].lv_tag;
    assign out_sums  = g_lvl[LEVELS-1].lv_sums;

endmodule

// File: rtl/xbar_spike_array_chk.sv
module xbar_spike_array_chk #(
    parameter int N_PRE  = 16,
    parameter int N_POST = 16,
    parameter int W_BITS = 8,
    parameter int TAG_W  = 4,
    parameter int SUM_W  = 12
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           in_valid,
    input logic [TAG_W-1:0]               in_tag,
    input logic [N_PRE-1:0]               in_spikes,
    input logic [N_POST*N_PRE*W_BITS-1:0] in_weights,
    input logic                           out_valid,
    input logic [TAG_W-1:0]               out_tag,
    input logic [N_POST*SUM_W-1:0]        out_sums
);

    localparam int LAT = xbar_pkg::tree_levels(N_PRE);

    logic [N_POST*SUM_W-1:0] ref_now;
    logic [LAT-1:0]          vld_pipe;
    logic [LAT-1:0]          zero_pipe;
    logic [TAG_W-1:0]        tag_pipe [LAT];
    logic [N_POST*SUM_W-1:0] ref_pipe [LAT];
    logic [7:0]              since_rst;

    // Behavioural model of the column sums, one weight at a time.
    always_comb begin
        for (int j = 0; j < N_POST; j++) begin
            int acc;
            acc = 0;
            for (int i = 0; i < N_PRE; i++) begin
                if (in_spikes[i])
                    acc += int'($signed(in_weights[(j*N_PRE+i)*W_BITS +: W_BITS]));
            end
            ref_now[j*SUM_W +: SUM_W] = SUM_W'(acc);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_pipe  <= '0;
            zero_pipe <= '0;
            since_rst <= '0;
            for (int s = 0; s < LAT; s++) begin
                tag_pipe[s] <= '0;
                ref_pipe[s] <= '0;
            end
        end else begin
            vld_pipe    <= {vld_pipe[LAT-2:0], in_valid};
            zero_pipe   <= {zero_pipe[LAT-2:0], (in_spikes == '0)};
            tag_pipe[0] <= in_tag;
            ref_pipe[0] <= ref_now;
            for (int s = 1; s < LAT; s++) begin
                tag_pipe[s] <= tag_pipe[s-1];
                ref_pipe[s] <= ref_pipe[s-1];
            end
            if (since_rst != 8'hFF) since_rst <= since_rst + 8'd1;
        end
    end

    // R4 and R6: the valid flag matches the input flag LAT cycles earlier
    p_valid_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vld_pipe[LAT-1]);

    // R5
    p_tag_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_tag == tag_pipe[LAT-1]);

    // R1, R8
    p_column_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_sums == ref_pipe[LAT-1]);

    // R3
    p_zero_spikes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && zero_pipe[LAT-1]) |-> out_sums == '0);

    // R7
    p_reset_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < 8'(LAT)) |-> !out_valid);

endmodule

bind xbar_spike_array xbar_spike_array_chk #(
    .N_PRE (N_PRE),
    .N_POST(N_POST),
    .W_BITS(W_BITS),
    .TAG_W (TAG_W),
    .SUM_W (SUM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_tag    (in_tag),
    .in_spikes (in_spikes),
    .in_weights(in_weights),
    .out_valid (out_valid),
    .out_tag   (out_tag),
    .out_sums  (out_sums)
);

// File: tb/xbar_spike_array_test.sv
module xbar_spike_array_test;

    localparam int PERIOD = 10;
    localparam int NPRE   = 16;
    localparam int NPOST  = 16;
    localparam int WB     = 8;
    localparam int TW     = 4;
    localparam int SW     = 12;
    localparam int LAT    = 4;
    localparam int WTOT   = NPOST*NPRE*WB;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                in_valid;
    logic [TW-1:0]       in_tag;
    logic [NPRE-1:0]     in_spikes;
    logic [WTOT-1:0]     in_weights;
    logic                out_valid;
    logic [TW-1:0]       out_tag;
    logic [NPOST*SW-1:0] out_sums;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    logic                exp_v [LAT];
    logic [TW-1:0]       exp_t [LAT];
    logic [NPOST*SW-1:0] exp_s [LAT];
    string               exp_r [LAT];

    always #(PERIOD/2) clk = ~clk;

    xbar_spike_array uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
        .in_spikes(in_spikes), .in_weights(in_weights),
        .out_valid(out_valid), .out_tag(out_tag), .out_sums(out_sums)
    );

    function automatic logic [NPOST*SW-1:0] model(input logic [NPRE-1:0] s,
                                                  input logic [WTOT-1:0] w);
        logic [NPOST*SW-1:0] r;
        for (int j = 0; j < NPOST; j++) begin
            int acc = 0;
            for (int i = 0; i < NPRE; i++)
                if (s[i]) acc += int'($signed(w[(j*NPRE+i)*WB +: WB]));
            r[j*SW +: SW] = SW'(acc);
        end
        return r;
    endfunction

    function automatic logic [WTOT-1:0] rand_w();
        logic [WTOT-1:0] w;
        for (int k = 0; k < WTOT/32; k++) w[k*32 +: 32] = $urandom;
        return w;
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [NPOST*SW-1:0] act, input logic [NPOST*SW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One cycle: compare the output due now, then drive the next pass.
    task automatic step(input logic v, input logic [TW-1:0] t,
                        input logic [NPRE-1:0] s, input logic [WTOT-1:0] w,
                        input string rq);
        int k;
        @(negedge clk);
        k = cyc % LAT;
        if (exp_v[k]) begin
            check(out_valid == 1'b1, "R4", "valid", {191'b0, out_valid}, {191'b0, 1'b1});
            check(out_tag == exp_t[k], "R5", "tag", {188'b0, out_tag}, {188'b0, exp_t[k]});
            check(out_sums == exp_s[k], exp_r[k], "sums", out_sums, exp_s[k]);
        end else begin
            check(out_valid == 1'b0, "R6", "bubble valid", {191'b0, out_valid}, '0);
        end
        in_valid   = v;
        in_tag     = t;
        in_spikes  = s;
        in_weights = w;
        exp_v[k]   = v;
        exp_t[k]   = t;
        exp_s[k]   = model(s, w);
        exp_r[k]   = rq;
        cyc++;
    endtask

    initial begin
        #(PERIOD*200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [WTOT-1:0] w;
        void'($urandom(32'd1729));
        for (int k = 0; k < LAT; k++) begin
            exp_v[k] = 1'b0; exp_t[k] = '0; exp_s[k] = '0; exp_r[k] = "R1";
        end
        rst_n = 1'b0; in_valid = 1'b0; in_tag = '0; in_spikes = '0; in_weights = '0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R7", "valid in reset", {191'b0, out_valid}, '0);
        rst_n = 1'b1;
        // R7: quiet window just after reset release, idle input
        for (int k = 0; k < LAT; k++) step(1'b0, '0, '0, '0, "R7");

        // R3: no spikes, random weights
        for (int k = 0; k < 6; k++) step(1'b1, TW'(k), '0, rand_w(), "R3");
        // R3: all spikes, random weights
        for (int k = 0; k < 4; k++) step(1'b1, TW'(k+6), '1, rand_w(), "R3");

        // R8: extreme weights
        w = '0;
        for (int k = 0; k < NPOST*NPRE; k++) w[k*WB +: WB] = 8'h80;
        step(1'b1, 4'hA, '1, w, "R8");
        step(1'b0, '0, '0, '0, "R6");
        for (int k = 0; k < NPOST*NPRE; k++) w[k*WB +: WB] = 8'h7F;
        step(1'b1, 4'hB, '1, w, "R8");

        // R2: single spike walks across the inputs
        for (int i = 0; i < NPRE; i++) step(1'b1, TW'(i), NPRE'(1) << i, rand_w(), "R2");

        // R6 and R1: random back-to-back with bubbles
        for (int k = 0; k < 400; k++) begin
            logic v;
            v = ($urandom % 4) != 0;
            step(v, TW'($urandom), NPRE'($urandom), rand_w(), "R1");
        end

        // drain
        for (int k = 0; k < LAT + 1; k++) step(1'b0, '0, '0, '0, "R6");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule